// File: doc/BRIEF.md
# Reloadable 24-bit Down-Counting Timer

This block is a down-counting interval timer with one output pin. A free-running prescaler turns the system clock into a count tick once every six clocks. The counter is 24 bits wide. Software writes a reload value one byte at a time. The two upper bytes wait in staging registers. Writing the low byte moves the whole 24-bit value into the reload register in one step, unless the mode register protects it.

A write to the mode register can start the timer, which copies the reload value into the counter. The same register can also halt the timer, or change the output polarity and the operating mode. In single-shot mode the output is active from start until the count has passed zero, and then the timer stops. In auto-reload mode each pass through zero produces a fixed eight-tick active pulse and reloads the counter.

A restart before zero reloads the counter with no pulse. An external test-enable input shortens the cycle: with it set, only the upper twelve counter bits decide when zero is reached.

Top module: `reload_timer24`

## Requirements
- R1: While rst_n is low at a clock edge, the mode register clears to 0x00, the timer stops, and timer_out sits at its idle level of 1.
- R2: When running, the counter decrements exactly once per six clocks. A reload value N gives N+1 ticks from start to the zero action.
- R3: Register select encoding: wr_sel 0 is the low byte, 1 the middle byte, 2 the high byte, 3 the mode register. Writes to select 1 or 2 only stage a byte. A select-0 write loads {high, middle, written byte} into the reload register together.
- R4: When mode bit 0 is 1, a low-byte write leaves the reload register unchanged.
- R5: A mode write with bit 7 set starts the timer and loads the reload value into the counter.
- R6: Mode bit 4 selects polarity. With 0 the output is active 0 and idle 1. With 1 it is active 1 and idle 0.
- R7: With mode bit 5 = 0 (single-shot), the output is active from start through N+1 ticks. It then returns to idle and the timer stays stopped until started again.
- R8: With mode bit 5 = 1 (auto-reload), each zero reloads the counter and drives an active pulse of exactly 8 ticks. With N = 8 the period is 9 ticks.
- R9: A start before the counter reaches zero reloads the counter, and no pulse is issued for the cut-short cycle.
- R10: A mode write with bit 7 = 0, bit 6 = 1 and bit 5 = 0 halts the timer. It also cancels any pulse, and the output goes idle.
- R11: With test_en = 1, zero is detected when the upper 12 counter bits are all zero.
- R12: While the timer is stopped and no pulse is pending, timer_out holds the idle level given by mode bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 low, 1 middle, 2 high byte, 3 mode |
| wr_data | input | 8 | Write data |
| test_en | input | 1 | Shortened zero detection on the upper 12 bits |
| timer_out | output | 1 | Timer output pin, polarity set by mode bit 4 |

## Verification
Every internal error shows up on timer_out, usually within one count tick (six clocks). A stale prescaler phase shifts every output edge by whole clocks. A wrong counter or reload value moves the end of the active window or the pulse spacing by multiples of six clocks. A leaked pulse after a restart or a halt appears as an extra active window within eight ticks. The bench therefore compares the pin against a behavioural model on every clock, and the internal state is checked in the same cycle through the bound properties.

// File: rtl/timer24_pkg.sv
// Shared constants for the reloadable timer: mode register bit positions
// and the default reset value of the mode register.
package timer24_pkg;
    localparam int BYTE_W    = 8;
    localparam int MB_PROT   = 0;   // reload register write protection
    localparam int MB_POL    = 4;   // output polarity, 1 = active high
    localparam int MB_AUTO   = 5;   // 1 = auto-reload, 0 = single-shot
    localparam int MB_HALT   = 6;   // halt request (with MB_AUTO clear)
    localparam int MB_START  = 7;   // start strobe
    localparam logic [BYTE_W-1:0] MODE_RST = 8'h00;
endpackage

// File: rtl/timer24_prescale.sv
// Prescaler: free-running divider that emits a one-clock tick every DIV
// clocks. Assumes DIV >= 1; the phase restarts at synchronous reset.
module timer24_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] div_q;

            // wrap the phase counter at DIV-1
            always_ff @(posedge clk) begin
                if (!rst_n)                      div_q <= '0;
                else if (div_q == PW'(DIV - 1))  div_q <= '0;
                else                             div_q <= div_q + PW'(1);
            end

            assign tick = (div_q == PW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/timer24_reload.sv
// Reload register with byte staging: upper bytes are held in staging
// registers and the whole value is captured when the low byte is written,
// unless protect is set. Assumes CNT_W is a multiple of BYTE_W and that the
// byte at select index i sits at bit i*BYTE_W.
module timer24_reload #(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              protect,
    output logic [CNT_W-1:0]  reload
);
    localparam int BYTES = CNT_W / BYTE_W;

    logic [BYTE_W-1:0] stage_q [1:BYTES-1];
    logic [CNT_W-1:0]  capture;
    logic [CNT_W-1:0]  reload_q;
    logic              low_wr;

    assign low_wr = wr_en && (wr_sel == '0);

    // hold the upper bytes until the low byte arrives
    always_ff @(posedge clk) begin
        for (int i = 1; i < BYTES; i++) begin
            if (!rst_n)                                stage_q[i] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(i)))   stage_q[i] <= wr_data;
        end
    end

    // assemble the value to be captured: staged upper bytes plus new low byte
    always_comb begin
        capture = '0;
        capture[BYTE_W-1:0] = wr_data;
        for (int i = 1; i < BYTES; i++) begin
            capture[i*BYTE_W +: BYTE_W] = stage_q[i];
        end
    end

    // capture all bytes at once on an unprotected low-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)                   reload_q <= '0;
        else if (low_wr && !protect)  reload_q <= capture;
    end

    assign reload = reload_q;
endmodule

// File: rtl/timer24_core.sv
// Timer core: mode register, down counter, run flag, pulse stretcher and
// output polarity. Start and halt writes take priority over a tick in the
// same clock; the zero action uses the mode value held before that clock.
module timer24_core
    import timer24_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SEL_W       = 2,
    parameter int PULSE_TICKS = 8,
    parameter int TEST_BITS   = 12,
    parameter int PW          = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              test_en,
    input  logic [CNT_W-1:0]  reload,
    output logic [BYTE_W-1:0] mode,
    output logic [CNT_W-1:0]  count,
    output logic              running,
    output logic [PW-1:0]     pulse_cnt,
    output logic              timer_out
);
    localparam int BYTES = CNT_W / BYTE_W;

    logic [BYTE_W-1:0] mode_q;
    logic [CNT_W-1:0]  count_q;
    logic              run_q;
    logic [PW-1:0]     pulse_q;
    logic              mode_wr, start_req, halt_req;
    logic              zero_full, zero_test, at_zero, active;
    logic              mode_unused;

    assign mode_wr   = wr_en && (wr_sel == SEL_W'(BYTES));
    assign start_req = mode_wr && wr_data[MB_START];
    assign halt_req  = mode_wr && !wr_data[MB_START] && wr_data[MB_HALT] && !wr_data[MB_AUTO];

    assign zero_full = (count_q == '0);
    generate
        if (TEST_BITS > 0 && TEST_BITS < CNT_W) begin : g_test
            assign zero_test = (count_q[CNT_W-1 -: TEST_BITS] == '0);
        end else begin : g_notest
            assign zero_test = zero_full;
        end
    endgenerate
    assign at_zero = test_en ? zero_test : zero_full;

    // store the mode byte on every write to the mode select
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= MODE_RST;
        else if (mode_wr)  mode_q <= wr_data;
    end

    // counter, run flag and pulse stretcher
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
            pulse_q <= '0;
        end else if (start_req) begin
            count_q <= reload;
            run_q   <= 1'b1;
            pulse_q <= '0;
        end else if (halt_req) begin
            run_q   <= 1'b0;
            pulse_q <= '0;
        end else if (tick) begin
            if (pulse_q != '0) pulse_q <= pulse_q - PW'(1);
            if (run_q) begin
                if (at_zero) begin
                    if (mode_q[MB_AUTO]) begin
                        count_q <= reload;
                        pulse_q <= PW'(PULSE_TICKS);
                    end else begin
                        run_q <= 1'b0;
                    end
                end else begin
                    count_q <= count_q - CNT_W'(1);
                end
            end
        end
    end

    // active level: whole run in single-shot, stretched pulse otherwise
    always_comb begin
        active    = (run_q && !mode_q[MB_AUTO]) || (pulse_q != '0);
        timer_out = mode_q[MB_POL] ? active : !active;
    end

    assign mode_unused = ^{mode_q[3:1], mode_q[MB_HALT], mode_q[MB_START]};

    assign mode      = mode_q;
    assign count     = count_q;
    assign running   = run_q;
    assign pulse_cnt = pulse_q;
endmodule

// File: rtl/reload_timer24.sv
// Top level of the reloadable down-counting timer: prescaler, reload
// register and core. One write port addresses three reload bytes and the
// mode register; test_en is supplied by whoever owns the shared test bit.
module reload_timer24
    import timer24_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int DIV         = 6,
    parameter int PULSE_TICKS = 8,
    parameter int TEST_BITS   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       test_en,
    output logic       timer_out
);
    localparam int BYTES = CNT_W / BYTE_W;
    localparam int SEL_W = $clog2(BYTES + 1);
    localparam int PW    = $clog2(PULSE_TICKS + 1);

    logic              tick_w;
    logic [CNT_W-1:0]  reload_w;
    logic [CNT_W-1:0]  count_w;
    logic [BYTE_W-1:0] mode_w;
    logic              running_w;
    logic [PW-1:0]     pulse_w;

    timer24_prescale #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w)
    );

    timer24_reload #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .protect (mode_w[MB_PROT]),
        .reload  (reload_w)
    );

    timer24_core #(
        .CNT_W(CNT_W), .SEL_W(SEL_W), .PULSE_TICKS(PULSE_TICKS),
        .TEST_BITS(TEST_BITS), .PW(PW)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .test_en   (test_en),
        .reload    (reload_w),
        .mode      (mode_w),
        .count     (count_w),
        .running   (running_w),
        .pulse_cnt (pulse_w),
        .timer_out (timer_out)
    );
endmodule

// File: rtl/timer24_checker.sv
// Property checker for reload_timer24, attached with bind. Relates the
// write port, prescaler tick, reload register, counter state and the pin.
module timer24_checker
    import timer24_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SEL_W       = 2,
    parameter int PULSE_TICKS = 8,
    parameter int PW          = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              tick,
    input logic [CNT_W-1:0]  reload,
    input logic [CNT_W-1:0]  count,
    input logic [BYTE_W-1:0] mode,
    input logic              running,
    input logic [PW-1:0]     pulse_cnt,
    input logic              timer_out
);
    localparam int BYTES = CNT_W / BYTE_W;

    logic mode_sel, start_w, halt_w, low_w;
    assign mode_sel = wr_en && (wr_sel == SEL_W'(BYTES));
    assign start_w  = mode_sel && wr_data[MB_START];
    assign halt_w   = mode_sel && !wr_data[MB_START] && wr_data[MB_HALT] && !wr_data[MB_AUTO];
    assign low_w    = wr_en && (wr_sel == '0);

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!running && timer_out == 1'b1));

    assert_count_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start_w) |=> $stable(count));

    assert_upper_stage_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != '0) |=> $stable(reload));

    assert_low_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (low_w && !mode[MB_PROT]) |=> (reload[BYTE_W-1:0] == $past(wr_data)));

    assert_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (low_w && mode[MB_PROT]) |=> $stable(reload));

    assert_start_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (running && count == $past(reload)));

    assert_single_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !mode[MB_AUTO]) |-> (timer_out == mode[MB_POL]));

    assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PW'(PULSE_TICKS));

    assert_restart_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (pulse_cnt == '0));

    assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_w |=> (!running && pulse_cnt == '0));

    assert_idle_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && pulse_cnt == '0) |-> (timer_out == !mode[MB_POL]));
endmodule

bind reload_timer24 timer24_checker #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .PULSE_TICKS(PULSE_TICKS), .PW(PW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .tick      (tick_w),
    .reload    (reload_w),
    .count     (count_w),
    .mode      (mode_w),
    .running   (running_w),
    .pulse_cnt (pulse_w),
    .timer_out (timer_out)
);

// File: tb/sim_reload_timer24.sv
// Bench: behavioural reference model compared with timer_out every clock.
module sim_reload_timer24;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       test_en = 1'b0;
    logic       timer_out;

    int    compared = 0;
    int    mismatched = 0;
    int    cyc = 0;
    bit    started = 1'b0;
    string cur_req = "R1";

    // reference model state
    int          m_pre, m_pls;
    bit          m_run;
    logic [23:0] m_cnt, m_rel;
    logic [7:0]  m_hi, m_mid, m_mode;

    reload_timer24 u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .test_en(test_en), .timer_out(timer_out)
    );

    always #5 clk = ~clk;

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        bit tk, st, hl, zr;
        int np;
        started <= 1'b1;
        if (!rst_n) begin
            m_pre = 0; m_pls = 0; m_run = 0;
            m_cnt = 0; m_rel = 0; m_hi = 0; m_mid = 0; m_mode = 0;
        end else begin
            tk = (m_pre == 5);
            m_pre = tk ? 0 : m_pre + 1;
            st = wr_en && wr_sel == 2'd3 && wr_data[7];
            hl = wr_en && wr_sel == 2'd3 && !wr_data[7] && wr_data[6] && !wr_data[5];
            if (st) begin
                m_cnt = m_rel; m_run = 1; m_pls = 0;
            end else if (hl) begin
                m_run = 0; m_pls = 0;
            end else if (tk) begin
                np = (m_pls > 0) ? m_pls - 1 : 0;
                zr = test_en ? (m_cnt[23:12] == 0) : (m_cnt == 0);
                if (m_run) begin
                    if (zr) begin
                        if (m_mode[5]) begin m_cnt = m_rel; np = 8; end
                        else m_run = 0;
                    end else m_cnt = m_cnt - 1;
                end
                m_pls = np;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: if (!m_mode[0]) m_rel = {m_hi, m_mid, wr_data};
                    2'd1: m_mid = wr_data;
                    2'd2: m_hi = wr_data;
                    default: m_mode = wr_data;
                endcase
            end
        end
    end

    // compare the pin with the model away from the active edge
    always @(negedge clk) begin
        bit act, exp_out;
        if (started) begin
            act = (m_run && !m_mode[5]) || (m_pls != 0);
            exp_out = m_mode[4] ? act : !act;
            compared++;
            if (timer_out !== exp_out) begin
                mismatched++;
                $display("FAIL %s: timer_out=%b expected %b at cycle %0d",
                         cur_req, timer_out, exp_out, cyc);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            mismatched++;
            $display("FAIL watchdog: cycle=%0d expected finish before %0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        idle(6);
        rst_n = 1'b1;
        cur_req = "R12";
        idle(30);
        // single-shot, active low, N=5
        cur_req = "R5";
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h05);
        wr(2'd3, 8'h80);
        cur_req = "R7";
        idle(60);
        cur_req = "R2";
        wr(2'd3, 8'h80);
        idle(50);
        // polarity flipped
        cur_req = "R6";
        wr(2'd3, 8'h90);
        idle(60);
        // staging without low byte leaves reload at 5
        cur_req = "R3";
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h80);
        idle(60);
        wr(2'd0, 8'h02);
        wr(2'd3, 8'h80);
        idle(1600);
        // protection
        cur_req = "R4";
        wr(2'd1, 8'h00); wr(2'd0, 8'h03);
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h40);
        wr(2'd3, 8'h81);
        idle(60);
        // auto-reload, minimum period
        cur_req = "R8";
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h08);
        wr(2'd3, 8'hA0);
        idle(300);
        wr(2'd3, 8'hB0);
        idle(200);
        // restarts before zero
        cur_req = "R9";
        wr(2'd0, 8'd20);
        wr(2'd3, 8'hA0);
        for (int k = 0; k < 5; k++) begin
            idle(60);
            wr(2'd3, 8'hA0);
        end
        idle(200);
        // halt
        cur_req = "R10";
        wr(2'd3, 8'h40);
        idle(100);
        cur_req = "R12";
        idle(30);
        // test mode: upper 12 bits decide zero
        cur_req = "R11";
        test_en = 1'b1;
        wr(2'd2, 8'h00); wr(2'd1, 8'h10); wr(2'd0, 8'h05);
        wr(2'd3, 8'hA0);
        idle(300);
        wr(2'd3, 8'h80);
        idle(100);
        test_en = 1'b0;
        idle(10);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule